// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block holds a small set of recent page translations so that most virtual addresses can be turned into physical addresses without reading the page table in memory. A lookup presents a 32-bit virtual address. The upper bits form the page number, and that number is compared against every stored entry at the same time. On a hit, the block returns the physical address and the stored permission bits combinationally, in the same cycle.

On a miss, an external page walker resolves the translation. When the walker finds a present entry, it offers that entry on the fill port, and the block installs it. Empty slots are used first. When every slot holds a translation, the least recently used one is replaced. Lookup hits and fills both count as uses. A flush input invalidates every entry in one cycle, for use when a new process starts running.

Top module: `tlb_assoc`

## Requirements
- R1: `lk_hit` is 1 in the same cycle when `lk_valid` is 1 and a valid entry's tag equals `lk_vaddr[31:12]`. A tag that differs in any single bit does not hit.
- R2: On a hit, `lk_paddr` equals {stored frame, `lk_vaddr[11:0]`} and `lk_perm` equals the stored 3-bit permission. Without a hit, both outputs are 0.
- R3: `lk_miss` is 1 exactly when `lk_valid` is 1 and there is no hit. With `lk_valid` at 0, neither `lk_hit` nor `lk_miss` is asserted.
- R4: An entry filled with `fill_valid` at 1 and `flush` at 0 is visible to lookups from the next cycle on.
- R5: While any entry is invalid, a fill does not displace a valid translation.
- R6: When all entries are valid, a fill of a new page replaces the entry whose last use is oldest. A lookup hit and a fill each count as a use of that entry.
- R7: A flush invalidates every entry in one cycle. Every lookup misses in the next cycle.
- R8: A fill presented in the same cycle as a flush is discarded.
- R9: A fill whose page is already held overwrites that entry rather than occupying a second slot.
- R10: When a lookup hit and a fill occur in the same cycle, only the fill's target is recorded as used.
- R11: After reset, every entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | Lookup requested, no translation held |
| lk_paddr | output | 32 | Physical address on hit |
| lk_perm | output | 3 | Permission bits on hit |
| fill_valid | input | 1 | Install a walker result |
| fill_vpn | input | 20 | Page number of the refill |
| fill_pfn | input | 20 | Frame number of the refill |
| fill_perm | input | 3 | Permission bits of the refill |

## Verification
A behavioural reference tracks, for every slot, a use timestamp kept in the bench. The bench drives long mixed streams of lookups, fills, re-fills of pages already held and rare flushes over a pool of 12 pages. A pool larger than the 8 slots keeps replacement active throughout.

The directed cases cover the following faults:
- A recency update on the wrong slot, or a lookup touch counted during a fill, evicts a page still in use, so a later lookup misses where the bench expects a hit.
- A duplicate fill that takes a fresh slot leaves a stale frame able to match.
- A flush that loses to a fill leaves a page that hits after the flush.
- Frame and offset fields joined in the wrong order produce a wrong physical address.

// File: rtl/tlb_assoc.sv
module tlb_assoc #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int OFF_W   = 12,
  parameter int PERM_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush,
  input  logic                      lk_valid,
  input  logic [VPN_W+OFF_W-1:0]    lk_vaddr,
  output logic                      lk_hit,
  output logic                      lk_miss,
  output logic [PFN_W+OFF_W-1:0]    lk_paddr,
  output logic [PERM_W-1:0]         lk_perm,
  input  logic                      fill_valid,
  input  logic [VPN_W-1:0]          fill_vpn,
  input  logic [PFN_W-1:0]          fill_pfn,
  input  logic [PERM_W-1:0]         fill_perm
);

  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IW-1:0] OLDEST = IW'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld_q;
  logic [VPN_W-1:0]   tag_q  [ENTRIES];
  logic [PFN_W-1:0]   pfn_q  [ENTRIES];
  logic [PERM_W-1:0]  perm_q [ENTRIES];
  logic [IW-1:0]      age_q  [ENTRIES];

  logic [ENTRIES-1:0] lk_match, fill_match;
  logic [IW-1:0]      hit_idx, dup_idx, free_idx, lru_idx, vict_idx, touch_idx;
  logic               any_hit, install, touch_en;

  wire [VPN_W-1:0] lk_vpn = lk_vaddr[VPN_W+OFF_W-1:OFF_W];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lk_match[g]   = vld_q[g] && (tag_q[g] == lk_vpn);
    assign fill_match[g] = vld_q[g] && (tag_q[g] == fill_vpn);
  end

  always_comb begin
    hit_idx  = '0;
    dup_idx  = '0;
    free_idx = '0;
    lru_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lk_match[i])          hit_idx  = IW'(i);
      if (fill_match[i])        dup_idx  = IW'(i);
      if (!vld_q[i])            free_idx = IW'(i);
      if (age_q[i] == OLDEST)   lru_idx  = IW'(i);
    end
  end

  assign any_hit  = |lk_match;
  assign lk_hit   = lk_valid && any_hit;
  assign lk_miss  = lk_valid && !any_hit;
  assign lk_paddr = lk_hit ? {pfn_q[hit_idx], lk_vaddr[OFF_W-1:0]} : '0;
  assign lk_perm  = lk_hit ? perm_q[hit_idx] : '0;

  assign install   = fill_valid && !flush;
  assign vict_idx  = (|fill_match) ? dup_idx : ((&vld_q) ? lru_idx : free_idx);
  assign touch_en  = install || (lk_hit && !flush);
  assign touch_idx = install ? vict_idx : hit_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (flush) begin
      vld_q <= '0;
    end else if (install) begin
      vld_q[vict_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (install) begin
      tag_q[vict_idx]  <= fill_vpn;
      pfn_q[vict_idx]  <= fill_pfn;
      perm_q[vict_idx] <= fill_perm;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= IW'(i);
    end else if (touch_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IW'(i) == touch_idx)             age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

endmodule

// File: rtl/tlb_assoc_chk.sv
module tlb_assoc_chk #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int OFF_W   = 12,
  parameter int PERM_W  = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   flush,
  input logic                   lk_valid,
  input logic [VPN_W+OFF_W-1:0] lk_vaddr,
  input logic                   lk_hit,
  input logic                   lk_miss,
  input logic [PFN_W+OFF_W-1:0] lk_paddr,
  input logic [PERM_W-1:0]      lk_perm,
  input logic                   fill_valid,
  input logic [VPN_W-1:0]       fill_vpn
);

  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && !lk_miss));

  a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]));

  a_r2_zero_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_paddr == '0 && lk_perm == '0));

  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flush) && lk_valid) |-> lk_miss);

  a_r4_fill_visible: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fill_valid && !flush) && lk_valid &&
     lk_vaddr[VPN_W+OFF_W-1:OFF_W] == $past(fill_vpn)) |-> lk_hit);

  a_r8_flush_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fill_valid && flush) && lk_valid) |-> !lk_hit);

endmodule

bind tlb_assoc tlb_assoc_chk #(
  .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .OFF_W(OFF_W), .PERM_W(PERM_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
  .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr), .lk_perm(lk_perm),
  .fill_valid(fill_valid), .fill_vpn(fill_vpn)
);

// File: tb/test_tlb_assoc.sv
module test_tlb_assoc;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic clk = 0, rst_n = 0, flush = 0, lk_valid = 0, fill_valid = 0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_hit, lk_miss;
  logic [31:0] lk_paddr;
  logic [2:0]  lk_perm, fill_perm = '0;
  logic [19:0] fill_vpn = '0, fill_pfn = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_assoc i_tlb_assoc (
    .clk(clk), .rst_n(rst_n), .flush(flush), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr), .lk_perm(lk_perm),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_perm(fill_perm)
  );

  int vectors = 0, errors = 0, tick = 0, gen = 0;
  bit         m_vld   [N];
  logic [19:0] m_vpn  [N];
  logic [19:0] m_pfn  [N];
  logic [2:0]  m_perm [N];
  int          m_stamp[N];

  function automatic logic [19:0] pool(input int k);
    return 20'h40000 + 20'(k) * 20'h01001;
  endfunction

  task automatic step(input bit lk, input logic [19:0] vpn, input logic [11:0] off,
                      input bit fl, input bit fv, input logic [19:0] fvpn, input string tag);
    bit eh; int ei; int tgt; logic [37:0] exp_v, got_v;
    logic [19:0] fpfn; logic [2:0] fperm;
    gen++;
    fpfn  = fvpn ^ {10'(gen), 10'h2A5};
    fperm = 3'(gen);
    @(negedge clk);
    lk_valid = lk; lk_vaddr = {vpn, off}; flush = fl;
    fill_valid = fv; fill_vpn = fvpn; fill_pfn = fpfn; fill_perm = fperm;
    #1;
    eh = 0; ei = 0;
    for (int i = 0; i < N; i++)
      if (lk && m_vld[i] && m_vpn[i] == vpn) begin eh = 1; ei = i; end
    exp_v = {eh, lk && !eh, eh ? {m_pfn[ei], off} : 32'h0, eh ? m_perm[ei] : 3'h0};
    got_v = {lk_hit, lk_miss, lk_paddr, lk_perm};
    vectors++;
    if (got_v !== exp_v) begin
      errors++;
      $display("FAIL %s: got hit=%b miss=%b pa=%h perm=%h expected hit=%b miss=%b pa=%h perm=%h",
               tag, got_v[37], got_v[36], got_v[35:3], got_v[2:0],
               exp_v[37], exp_v[36], exp_v[35:3], exp_v[2:0]);
    end
    @(posedge clk);
    if (fl) begin
      for (int i = 0; i < N; i++) m_vld[i] = 0;
    end else if (fv) begin
      tgt = -1;
      for (int i = 0; i < N; i++) if (m_vld[i] && m_vpn[i] == fvpn) tgt = i;
      if (tgt < 0) for (int i = N - 1; i >= 0; i--) if (!m_vld[i]) tgt = i;
      if (tgt < 0) begin
        tgt = 0;
        for (int i = 1; i < N; i++) if (m_stamp[i] < m_stamp[tgt]) tgt = i;
      end
      m_vld[tgt] = 1; m_vpn[tgt] = fvpn; m_pfn[tgt] = fpfn; m_perm[tgt] = fperm;
      m_stamp[tgt] = ++tick;
    end else if (eh) begin
      m_stamp[ei] = ++tick;
    end
  endtask

  task automatic look(input logic [19:0] vpn, input string tag);
    step(1, vpn, 12'(vpn * 7), 0, 0, 20'h0, tag);
  endtask
  task automatic fill(input logic [19:0] vpn, input string tag);
    step(0, 20'h0, 12'h0, 0, 1, vpn, tag);
  endtask
  task automatic sweep(input string tag);
    for (int k = 0; k < 12; k++) look(pool(k), tag);
  endtask
  task automatic fresh8();
    step(0, 20'h0, 12'h0, 1, 0, 20'h0, "R7");
    for (int k = 0; k < 8; k++) fill(pool(k), "R4");
  endtask

  bit done = 0;
  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    for (int i = 0; i < N; i++) begin m_vld[i] = 0; m_stamp[i] = 0; end
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R11: reset leaves nothing valid
    sweep("R11");
    // R4, R2: fill 8 and read each back with frame and offset
    for (int k = 0; k < 8; k++) fill(pool(k), "R4");
    for (int k = 0; k < 8; k++) step(1, pool(k), 12'hFFF - 12'(k), 0, 0, 20'h0, "R2");
    // R1: single-bit tag differences miss
    for (int b = 0; b < 20; b++) look(pool(3) ^ (20'h1 << b), "R1");
    // R3: no request, no hit and no miss
    step(0, pool(2), 12'h123, 0, 0, 20'h0, "R3");
    // R5: after a flush, 8 fills all stay resident
    fresh8();
    sweep("R5");
    // R6: touch oldest, then new page evicts the next oldest
    fresh8();
    look(pool(0), "R6");
    fill(pool(8), "R6");
    sweep("R6");
    // R9: re-fill of a held page replaces in place
    fresh8();
    fill(pool(3), "R9");
    fill(pool(9), "R9");
    sweep("R9");
    // R10: hit and fill together; only the fill target becomes recent
    fresh8();
    step(1, pool(1), 12'h055, 0, 1, pool(8), "R10");
    fill(pool(9), "R10");
    sweep("R10");
    // R7: flush empties all entries
    step(0, 20'h0, 12'h0, 1, 0, 20'h0, "R7");
    sweep("R7");
    // R8: fill in the same cycle as a flush is dropped
    step(0, 20'h0, 12'h0, 1, 1, pool(4), "R8");
    look(pool(4), "R8");
    // R6: long mixed stream over 12 pages
    r = 16'hACE1;
    for (int n = 0; n < 4000; n++) begin
      r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
      if (r[7:0] == 8'h5A)
        step(0, 20'h0, 12'h0, 1, 0, 20'h0, "R7");
      else case (r[1:0])
        2'd0, 2'd1: step(1, pool(int'(r[11:8]) % 12), r[15:4], 0, 0, 20'h0, "R6");
        2'd2:       step(0, 20'h0, 12'h0, 0, 1, pool(int'(r[14:11]) % 12), "R6");
        default:    step(1, pool(int'(r[11:8]) % 12), r[13:2], 0, 1,
                         pool(int'(r[15:12]) % 12), "R10");
      endcase
    end
    sweep("R6");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule